// File: doc/BRIEF.md
# CAN Controller Control Register File

This block is the software-visible control and status bank of a CAN controller. It sits on a simple 32-bit register bus with address, write strobe, read strobe, write data and registered read data. It holds the operating-mode word, a write-only command port, a live status word with the last captured bus error, interrupt flags with their enables, and a copy of the transmit and receive error counts.

The protocol engine feeds it with event strobes, a status byte, error-capture fields and counter values. In return it receives the mode bits, single-cycle command pulses and a counter-clear strobe. One combined interrupt line goes to the system interrupt controller.

Two configuration fields, filter selection and sleep, are locked while the controller is running. Software can change them only while the reset-mode bit is set.

Top module: `can_ctrl_regfile`

## Requirements
- R1: The mode word (offset 0x00) resets to 0x01, with bit 0 reset mode, bit 1 listen-only, bit 2 loopback, bit 3 single filter and bit 4 sleep. Bits 2:0 take the written value on any write.
- R2: Bits 4:3 of the mode word take the written value only if reset mode (bit 0) was already set before that write; otherwise they keep their value.
- R3: A write to the command offset (0x04) drives bits 5:0 of the write data on `cmd_pulse` for exactly the next cycle (0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-reception, 5 bus-off). A read of that offset returns zero.
- R4: Each `evt_set` bit sets the interrupt flag at the same position in the flag register (offset 0x0C): 0 receive, 1 transmit done, 2 error warning, 3 overrun, 4 wakeup, 5 error passive, 6 arbitration lost, 7 bus error.
- R5: Writing ones to the flag offset clears those flags, and written zeros leave flags unchanged. When a set and a clear hit the same flag in the same cycle, the flag ends set.
- R6: `irq` is high exactly when some flag is set whose bit in the enable register (offset 0x10, same bit positions) is set.
- R7: The status word (offset 0x08) carries the engine status byte in bits 7:0, registered every cycle, and reads 0x3C right after reset.
- R8: When `err_cap_valid` is high, status bits 23:22 capture the error kind (0 bit, 1 form, 2 stuff, 3 other), bit 21 the direction (1 receiving) and bits 20:16 the segment code. These fields hold until the next capture.
- R9: The counter word (offset 0x14) shows the transmit count in bits 7:0 and the receive count in bits 23:16. `cnt_upd` loads them. A write to the offset clears both counts, overrides a same-cycle load, and raises `errcnt_clr` during that write cycle.
- R10: Read data appears one cycle after the read strobe. Unmapped offsets read zero, and `bus_rdata` is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Byte offset of register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 1 | Combined interrupt line |
| mode_reset | output | 1 | Reset mode |
| mode_listen | output | 1 | Listen-only mode |
| mode_loopback | output | 1 | Loopback mode |
| mode_single_filter | output | 1 | Single-filter select |
| mode_sleep | output | 1 | Sleep request |
| cmd_pulse | output | 6 | One-cycle command strobes |
| errcnt_clr | output | 1 | Counter clear towards the engine |
| evt_set | input | 8 | Interrupt event strobes from the engine |
| eng_status | input | 8 | Live status byte from the engine |
| err_cap_valid | input | 1 | Load strobe for the error capture |
| err_kind | input | 2 | Captured error kind |
| err_dir | input | 1 | Captured error direction |
| err_seg | input | 5 | Captured frame segment code |
| cnt_upd | input | 1 | Load strobe for the error counts |
| tx_err_cnt | input | 8 | Transmit error count from the engine |
| rx_err_cnt | input | 8 | Receive error count from the engine |

## Verification
The assertions check on every cycle that the locked mode bits do not move outside reset mode and that a command pulse never outlasts its write. They also check that a set event always leaves its flag high, that a flag only falls after a clear write, that a counter write always leaves both counts at zero, and that idle cycles and command-offset reads return zero. The bench scenarios must show the reset values, the exact sequence of mode words through lock and unlock, and the field positions of the status, capture and counter words. They must also show that the interrupt line follows random mixes of events, clears and enables, which the bench tracks with its own reference model.

// File: rtl/can_rf_pkg.sv
package can_rf_pkg;

  localparam int unsigned MODE_W   = 5;
  localparam int unsigned CMD_W    = 6;
  localparam int unsigned IRQ_W    = 8;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned SEG_W    = 5;

  localparam logic [MODE_W-1:0] MODE_RST_VAL = 5'b00001;
  localparam logic [STAT_W-1:0] STAT_RST_VAL = 8'h3C;

  // captured bus error
  typedef struct packed {
    logic [1:0]       kind;
    logic             dir;
    logic [SEG_W-1:0] seg;
  } err_cap_t;

  // mode update: run-time bits always, locked bits only from reset mode
  function automatic logic [MODE_W-1:0] mode_next(input logic [MODE_W-1:0] cur,
                                                  input logic [MODE_W-1:0] wr);
    logic [MODE_W-1:0] n;
    n      = cur;
    n[2:0] = wr[2:0];
    if (cur[0]) n[MODE_W-1:3] = wr[MODE_W-1:3];
    return n;
  endfunction

  function automatic logic irq_any(input logic [IRQ_W-1:0] flags,
                                   input logic [IRQ_W-1:0] en);
    return |(flags & en);
  endfunction

  function automatic logic [31:0] status_word(input err_cap_t cap,
                                              input logic [STAT_W-1:0] st);
    return {8'h00, cap, 8'h00, st};
  endfunction

  function automatic logic [31:0] count_word(input logic [CNT_W-1:0] tx,
                                             input logic [CNT_W-1:0] rx);
    return {8'h00, rx, 8'h00, tx};
  endfunction

endpackage

// File: rtl/can_rf_mode.sv
module can_rf_mode
  import can_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_RST_VAL;
    else if (wr_en) mode_q <= mode_next(mode_q, wdata);
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[0] |=> $stable(mode_q[MODE_W-1:3])); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q)); // R1

endmodule

// File: rtl/can_rf_cmd.sv
module can_rf_cmd
  import can_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] pulse_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pulse_q <= '0;
    else if (wr_en) pulse_q <= wdata;
    else            pulse_q <= '0;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0 && !wr_en) |=> pulse_q == '0); // R3

endmodule

// File: rtl/can_rf_irq.sv
module can_rf_irq
  import can_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt_set,
  input  logic             clr_wr,
  input  logic             en_wr,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] flag_q,
  output logic [IRQ_W-1:0] en_q,
  output logic             irq
);

  logic [IRQ_W-1:0] clr_strobe;
  assign clr_strobe = clr_wr ? wdata : '0;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flag_q[i] <= 1'b0;
      else if (evt_set[i])    flag_q[i] <= 1'b1;
      else if (clr_strobe[i]) flag_q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[i] |=> flag_q[i]); // R5
    AST_CLR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(clr_strobe[i])); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wdata;
  end

  assign irq = irq_any(flag_q, en_q);

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R6

endmodule

// File: rtl/can_rf_errcnt.sv
module can_rf_errcnt
  import can_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wr,
  input  logic             upd,
  input  logic [CNT_W-1:0] tx_in,
  input  logic [CNT_W-1:0] rx_in,
  output logic [CNT_W-1:0] tx_q,
  output logic [CNT_W-1:0] rx_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (clr_wr) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (upd) begin
      tx_q <= tx_in;
      rx_q <= rx_in;
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (tx_q == '0 && rx_q == '0)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !upd) |=> ($stable(tx_q) && $stable(rx_q))); // R9

endmodule

// File: rtl/can_ctrl_regfile.sv
module can_ctrl_regfile
  import can_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              mode_reset,
  output logic              mode_listen,
  output logic              mode_loopback,
  output logic              mode_single_filter,
  output logic              mode_sleep,
  output logic [CMD_W-1:0]  cmd_pulse,
  output logic              errcnt_clr,
  input  logic [IRQ_W-1:0]  evt_set,
  input  logic [STAT_W-1:0] eng_status,
  input  logic              err_cap_valid,
  input  logic [1:0]        err_kind,
  input  logic              err_dir,
  input  logic [SEG_W-1:0]  err_seg,
  input  logic              cnt_upd,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt
);

  localparam logic [ADDR_W-1:0] OFS_MODE   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CMD    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_FLAGS  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_ENABLE = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_COUNT  = ADDR_W'(8'h14);

  // named write decodes
  logic wr_mode, wr_cmd, wr_flags, wr_enable, wr_count;
  assign wr_mode   = bus_wr && (bus_addr == OFS_MODE);
  assign wr_cmd    = bus_wr && (bus_addr == OFS_CMD);
  assign wr_flags  = bus_wr && (bus_addr == OFS_FLAGS);
  assign wr_enable = bus_wr && (bus_addr == OFS_ENABLE);
  assign wr_count  = bus_wr && (bus_addr == OFS_COUNT);

  logic wdata_unused;
  assign wdata_unused = ^bus_wdata[DATA_W-1:IRQ_W];

  logic [MODE_W-1:0] mode_q;
  logic [IRQ_W-1:0]  flag_q, en_q;
  logic [CNT_W-1:0]  tx_q, rx_q;
  logic [STAT_W-1:0] status_q;
  err_cap_t          cap_q;

  can_rf_mode u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mode),
    .wdata(bus_wdata[MODE_W-1:0]), .mode_q(mode_q)
  );

  can_rf_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd),
    .wdata(bus_wdata[CMD_W-1:0]), .pulse_q(cmd_pulse)
  );

  can_rf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .clr_wr(wr_flags),
    .en_wr(wr_enable), .wdata(bus_wdata[IRQ_W-1:0]),
    .flag_q(flag_q), .en_q(en_q), .irq(irq)
  );

  can_rf_errcnt u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_wr(wr_count), .upd(cnt_upd),
    .tx_in(tx_err_cnt), .rx_in(rx_err_cnt), .tx_q(tx_q), .rx_q(rx_q)
  );

  assign errcnt_clr = wr_count;

  assign mode_reset         = mode_q[0];
  assign mode_listen        = mode_q[1];
  assign mode_loopback      = mode_q[2];
  assign mode_single_filter = mode_q[3];
  assign mode_sleep         = mode_q[4];

  // status sampling and error capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STAT_RST_VAL;
      cap_q    <= '0;
    end else begin
      status_q <= eng_status;
      if (err_cap_valid) cap_q <= '{kind: err_kind, dir: err_dir, seg: err_seg};
    end
  end

  // read mux and one-cycle registered return
  logic [31:0] rd_word;
  always_comb begin
    unique case (bus_addr)
      OFS_MODE:   rd_word = {{(32-MODE_W){1'b0}}, mode_q};
      OFS_STATUS: rd_word = status_word(cap_q, status_q);
      OFS_FLAGS:  rd_word = {{(32-IRQ_W){1'b0}}, flag_q};
      OFS_ENABLE: rd_word = {{(32-IRQ_W){1'b0}}, en_q};
      OFS_COUNT:  rd_word = count_word(tx_q, rx_q);
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= DATA_W'(rd_word);
    else             bus_rdata <= '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0); // R10
  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_CMD) |=> bus_rdata == '0); // R3
  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> $past(wr_cmd)); // R3
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !err_cap_valid |=> $stable(cap_q)); // R8

endmodule

// File: tb/can_ctrl_regfile_tb.sv
module can_ctrl_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, mode_reset, mode_listen, mode_loopback, mode_single_filter, mode_sleep;
  logic [5:0]  cmd_pulse;
  logic        errcnt_clr;
  logic [7:0]  evt_set = '0;
  logic [7:0]  eng_status = 8'h3C;
  logic        err_cap_valid = 1'b0;
  logic [1:0]  err_kind = '0;
  logic        err_dir = 1'b0;
  logic [4:0]  err_seg = '0;
  logic        cnt_upd = 1'b0;
  logic [7:0]  tx_err_cnt = '0, rx_err_cnt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_ctrl_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .mode_reset(mode_reset), .mode_listen(mode_listen), .mode_loopback(mode_loopback),
    .mode_single_filter(mode_single_filter), .mode_sleep(mode_sleep),
    .cmd_pulse(cmd_pulse), .errcnt_clr(errcnt_clr), .evt_set(evt_set),
    .eng_status(eng_status), .err_cap_valid(err_cap_valid), .err_kind(err_kind),
    .err_dir(err_dir), .err_seg(err_seg), .cnt_upd(cnt_upd),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt)
  );

  // bench reference functions
  function automatic logic [4:0] ref_mode(input logic [4:0] cur, input logic [4:0] wr);
    logic [4:0] locked;
    locked = cur[0] ? wr : cur;
    return {locked[4:3], wr[2:0]};
  endfunction

  function automatic logic [7:0] ref_flags(input logic [7:0] cur, input logic [7:0] set,
                                           input logic [7:0] clr);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = set[b] ? 1'b1 : (clr[b] ? 1'b0 : cur[b]);
    return r;
  endfunction

  function automatic logic ref_irq(input logic [7:0] f, input logic [7:0] e);
    logic any;
    any = 1'b0;
    for (int b = 0; b < 8; b++) if (f[b] && e[b]) any = 1'b1;
    return any;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [4:0]  m_mode;
    logic [7:0]  m_flags, m_en;
    int unsigned seed;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_read(8'h00, rd); chk("R1 reset mode", rd, 32'h1);
    bus_read(8'h08, rd); chk("R7 reset status", rd, 32'h3C);
    bus_read(8'h0C, rd); chk("R4 reset flags", rd, 32'h0);
    bus_read(8'h14, rd); chk("R9 reset counts", rd, 32'h0);
    chk("R6 reset irq", {31'b0, irq}, 32'h0);
    chk("R3 reset cmd", {26'b0, cmd_pulse}, 32'h0);

    // mode lock sequence
    m_mode = 5'h01;
    bus_write(8'h00, 32'h1F); m_mode = ref_mode(m_mode, 5'h1F);
    bus_read(8'h00, rd); chk("R1 write in reset", rd, {27'b0, m_mode});
    bus_write(8'h00, 32'h18); m_mode = ref_mode(m_mode, 5'h18);
    bus_read(8'h00, rd); chk("R2 leave reset", rd, 32'h18);
    bus_write(8'h00, 32'h06); m_mode = ref_mode(m_mode, 5'h06);
    bus_read(8'h00, rd); chk("R2 locked bits", rd, 32'h1E);
    chk("R1 mode pins", {27'b0, mode_sleep, mode_single_filter, mode_loopback, mode_listen, mode_reset}, 32'h1E);
    bus_write(8'h00, 32'h01); m_mode = ref_mode(m_mode, 5'h01);
    bus_read(8'h00, rd); chk("R2 enter reset keeps lock", rd, 32'h19);
    bus_write(8'h00, 32'h01); m_mode = ref_mode(m_mode, 5'h01);
    bus_read(8'h00, rd); chk("R2 unlocked clear", rd, 32'h01);

    // command pulses
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'hFFFF_FF21; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R3 pulse value", {26'b0, cmd_pulse}, 32'h21);
    @(negedge clk);
    chk("R3 pulse ends", {26'b0, cmd_pulse}, 32'h0);
    bus_read(8'h04, rd); chk("R3 cmd reads zero", rd, 32'h0);

    // flags, enables, irq
    m_flags = 8'h00; m_en = 8'h00;
    @(negedge clk); evt_set = 8'h81; @(negedge clk); evt_set = 8'h00;
    m_flags = ref_flags(m_flags, 8'h81, 8'h00);
    bus_read(8'h0C, rd); chk("R4 flags set", rd, 32'h81);
    chk("R6 no enable no irq", {31'b0, irq}, 32'h0);
    bus_write(8'h10, 32'h01); m_en = 8'h01;
    chk("R6 enabled irq", {31'b0, irq}, 32'h1);
    bus_write(8'h0C, 32'h01); m_flags = ref_flags(m_flags, 8'h00, 8'h01);
    chk("R5 clear drops irq", {31'b0, irq}, 32'h0);
    bus_read(8'h0C, rd); chk("R5 other flag kept", rd, 32'h80);
    // set and clear together
    @(negedge clk);
    evt_set = 8'h04; bus_addr = 8'h0C; bus_wdata = 32'h84; bus_wr = 1'b1;
    @(negedge clk);
    evt_set = 8'h00; bus_wr = 1'b0;
    m_flags = ref_flags(m_flags, 8'h04, 8'h84);
    bus_read(8'h0C, rd); chk("R5 set wins", rd, {24'b0, m_flags});

    // status and capture
    @(negedge clk);
    eng_status = 8'hA5; err_cap_valid = 1'b1; err_kind = 2'd2; err_dir = 1'b1; err_seg = 5'h1A;
    @(negedge clk);
    err_cap_valid = 1'b0; err_kind = 2'd0; err_dir = 1'b0; err_seg = 5'h00;
    bus_read(8'h08, rd); chk("R7 R8 status word", rd, 32'h00BA_00A5);
    eng_status = 8'h3C;
    @(negedge clk);
    bus_read(8'h08, rd); chk("R8 capture held", rd, 32'h00BA_003C);

    // counters
    @(negedge clk);
    cnt_upd = 1'b1; tx_err_cnt = 8'h33; rx_err_cnt = 8'h81;
    @(negedge clk);
    cnt_upd = 1'b0;
    bus_read(8'h14, rd); chk("R9 counts", rd, 32'h0081_0033);
    @(negedge clk);
    bus_addr = 8'h14; bus_wdata = 32'h0; bus_wr = 1'b1; cnt_upd = 1'b1;
    #1 chk("R9 clear strobe", {31'b0, errcnt_clr}, 32'h1);
    @(negedge clk);
    bus_wr = 1'b0; cnt_upd = 1'b0;
    bus_read(8'h14, rd); chk("R9 write clears", rd, 32'h0);

    // read path
    bus_read(8'h3C, rd); chk("R10 unmapped", rd, 32'h0);
    @(negedge clk);
    chk("R10 idle zero", bus_rdata, 32'h0);

    // random mix against reference model
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      logic [7:0] rs, rc;
      op = $urandom % 4;
      rs = 8'($urandom); rc = 8'($urandom);
      case (op)
        0: begin
          bus_write(8'h00, {24'b0, rc});
          m_mode = ref_mode(m_mode, rc[4:0]);
        end
        1: begin
          @(negedge clk);
          evt_set = rs & 8'($urandom); bus_addr = 8'h0C; bus_wdata = {24'b0, rc};
          bus_wr = $urandom % 2 == 0;
          m_flags = ref_flags(m_flags, evt_set, bus_wr ? rc : 8'h00);
          @(negedge clk);
          evt_set = 8'h00; bus_wr = 1'b0;
        end
        2: begin
          bus_write(8'h10, {24'b0, rs});
          m_en = rs;
        end
        default: begin
          bus_read(8'h0C, rd); chk("R4 R5 random flags", rd, {24'b0, m_flags});
          bus_read(8'h00, rd); chk("R1 R2 random mode", rd, {27'b0, m_mode});
        end
      endcase
      chk("R6 random irq", {31'b0, irq}, {31'b0, ref_irq(m_flags, m_en)});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule